// File: doc/BRIEF.md
# Fan Tachometer Period Capture

This block measures how long a cooling fan takes to turn once. It counts system-clock cycles between the tachometer rising edges that open and close one revolution. A parameter sets how many tach pulses make up a revolution. The count is stored as a 16-bit period, in clock cycles, and is not a frequency. A slow or stopped fan drives the count to its ceiling, and that ceiling value is reported as a stall.

A host reads the period as two bytes over a simple byte-wide register port (address, read strobe, write strobe, write data, read data). Reading the low byte first takes a snapshot of the matching high byte. That snapshot is held until the high byte has also been read, so a capture that lands between the two reads cannot split the pair.

The same port also writes a 16-bit target period, in clock cycles per revolution. This value is driven out as the setpoint for a software speed-control loop that sits outside this block.

Top module: `fan_period_meter`

## Requirements
- R1: After reset, reads of addresses 0x08 and 0x09 return 0x00, reads of 0x1E and 0x1F return 0xFF, `target_period` is 0xFFFF and `rdata` is 0x00.
- R2: `tach_i` passes through a two-flop synchronizer. The first synchronized rising edge after reset only starts a measurement. After that, every PPR-th rising edge (PPR defaults to 2) captures the number of clock cycles since the previous capturing edge.
- R3: The running count saturates at 0xFFFF and never wraps. When it reaches 0xFFFF, the value 0xFFFF is captured as a stall indication.
- R4: A read of 0x08 returns bits 7:0 of the latest capture and freezes the high byte at bits 15:8 of that same capture. While frozen, a read of 0x09 returns the frozen byte and releases the freeze, even if newer captures have arrived.
- R5: A read of 0x09 with no freeze pending returns bits 15:8 of the latest capture and does not start a freeze.
- R6: Writes to 0x1E and 0x1F load bits 7:0 and 15:8 of the target period. The target period can be read back at those addresses and is driven on `target_period`.
- R7: Writes to 0x08 and 0x09 change nothing.
- R8: Reads of any address other than 0x08, 0x09, 0x1E and 0x1F return 0x00.
- R9: `rdata` is updated on the clock edge that samples `rd_en` high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the period time base |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| tach_i | input | 1 | Raw tachometer pulse from the fan |
| addr | input | 8 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| target_period | output | 16 | Target period setpoint for the speed loop |

## Verification
A tach rising edge driven between clock edges shows up in the readable period on the third rising clock edge after it, because of the two synchronizer flops plus the capture register. Read data appears on the edge that samples the strobe. The bench drives every input on falling edges. It spaces tach edges an exact number of cycles apart, so the expected period is simply the sum of the programmed gaps. It then waits two more falling edges before the first read of each capture and samples `rdata` on the falling edge after each strobe. Each measurement phase is padded to a fixed length, so the read traffic never shifts the next revolution's expected count.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int PERIOD_W = 16;
  localparam int BYTE_W   = 8;
  localparam logic [7:0] A_MEAS_LO = 8'h08;
  localparam logic [7:0] A_MEAS_HI = 8'h09;
  localparam logic [7:0] A_TGT_LO  = 8'h1E;
  localparam logic [7:0] A_TGT_HI  = 8'h1F;
  localparam logic [PERIOD_W-1:0] PERIOD_MAX = '1;
endpackage

// File: rtl/tach_edge_det.sv
module tach_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    logic d_in;
    if (g == 0) begin : g_first
      assign d_in = tach_i;
    end else begin : g_rest
      assign d_in = sync_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else        sync_q[g] <= d_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rev_period_counter.sv
module rev_period_counter
  import fpm_pkg::*;
#(
  parameter int PPR = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise_i,
  output logic                cap_vld_o,
  output logic [PERIOD_W-1:0] cap_val_o
);
  localparam int EW = (PPR > 1) ? $clog2(PPR) : 1;
  localparam logic [EW-1:0] LAST_EDGE = EW'(PPR - 1);

  logic [PERIOD_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [EW-1:0]       edges_q, edges_d;
  logic                armed_q, armed_d;

  always_comb begin
    cnt_inc   = (cnt_q == PERIOD_MAX) ? PERIOD_MAX : cnt_q + 1'b1;
    cnt_d     = cnt_inc;
    edges_d   = edges_q;
    armed_d   = armed_q;
    cap_vld_o = 1'b0;
    cap_val_o = cnt_inc;
    if (rise_i) begin
      if (!armed_q) begin
        armed_d = 1'b1;
        cnt_d   = '0;
        edges_d = '0;
      end else if (edges_q == LAST_EDGE) begin
        cap_vld_o = 1'b1;
        cnt_d     = '0;
        edges_d   = '0;
      end else begin
        edges_d = edges_q + 1'b1;
      end
    end else if (cnt_q == PERIOD_MAX - 1'b1) begin
      cap_vld_o = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      edges_q <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      edges_q <= edges_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/fpm_regs.sv
module fpm_regs
  import fpm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_vld_i,
  input  logic [PERIOD_W-1:0] cap_val_i,
  input  logic [7:0]          addr,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   rdata,
  output logic [PERIOD_W-1:0] target_o
);
  logic [PERIOD_W-1:0] shadow_q, tgt_q, tgt_d;
  logic [BYTE_W-1:0]   hold_hi_q, rdata_q, rd_mux;
  logic                frozen_q, frozen_d;
  logic                lo_rd, hi_rd, tlo_wr, thi_wr;

  always_comb begin
    lo_rd  = rd_en && (addr == A_MEAS_LO);
    hi_rd  = rd_en && (addr == A_MEAS_HI);
    tlo_wr = wr_en && (addr == A_TGT_LO);
    thi_wr = wr_en && (addr == A_TGT_HI);

    frozen_d = frozen_q;
    if (lo_rd)      frozen_d = 1'b1;
    else if (hi_rd) frozen_d = 1'b0;

    tgt_d = tgt_q;
    if (tlo_wr) tgt_d[BYTE_W-1:0]        = wdata;
    if (thi_wr) tgt_d[PERIOD_W-1:BYTE_W] = wdata;

    unique case (addr)
      A_MEAS_LO: rd_mux = shadow_q[BYTE_W-1:0];
      A_MEAS_HI: rd_mux = frozen_q ? hold_hi_q : shadow_q[PERIOD_W-1:BYTE_W];
      A_TGT_LO:  rd_mux = tgt_q[BYTE_W-1:0];
      A_TGT_HI:  rd_mux = tgt_q[PERIOD_W-1:BYTE_W];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q  <= '0;
      hold_hi_q <= '0;
      frozen_q  <= 1'b0;
      tgt_q     <= '1;
      rdata_q   <= '0;
    end else begin
      if (cap_vld_i) shadow_q  <= cap_val_i;
      if (lo_rd)     hold_hi_q <= shadow_q[PERIOD_W-1:BYTE_W];
      if (rd_en)     rdata_q   <= rd_mux;
      frozen_q <= frozen_d;
      tgt_q    <= tgt_d;
    end
  end

  assign rdata    = rdata_q;
  assign target_o = tgt_q;
endmodule

// File: rtl/fan_period_meter.sv
module fan_period_meter
  import fpm_pkg::*;
#(
  parameter int PPR         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tach_i,
  input  logic [7:0]  addr,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [15:0] target_period
);
  logic                rise;
  logic                cap_vld;
  logic [PERIOD_W-1:0] cap_val;

  tach_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .tach_i(tach_i), .rise_o(rise)
  );

  rev_period_counter #(.PPR(PPR)) u_cnt (
    .clk(clk), .rst_n(rst_n), .rise_i(rise),
    .cap_vld_o(cap_vld), .cap_val_o(cap_val)
  );

  fpm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cap_vld_i(cap_vld), .cap_val_i(cap_val),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .target_o(target_period)
  );
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic [15:0] target_period
);
  logic tgt_wr, known_addr;
  assign tgt_wr     = wr_en && (addr == 8'h1E || addr == 8'h1F);
  assign known_addr = (addr == 8'h08) || (addr == 8'h09) ||
                      (addr == 8'h1E) || (addr == 8'h1F);

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  a_r8_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !known_addr) |=> (rdata == 8'h00));

  a_r6_tgt_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h1E) |=> (target_period[7:0] == $past(wdata)));

  a_r6_tgt_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h1F) |=> (target_period[15:8] == $past(wdata)));

  a_r7_tgt_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_wr |=> $stable(target_period));
endmodule

bind fan_period_meter fpm_checker u_chk (.*);

// File: tb/sim_fan_period_meter.sv
module sim_fan_period_meter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tach_i;
  logic [7:0]  addr;
  logic        rd_en;
  logic        wr_en;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [15:0] target_period;

  int unsigned n_total = 0;
  int unsigned n_fail  = 0;
  bit          done    = 1'b0;

  always #2 clk = ~clk;

  fan_period_meter u0 (
    .clk(clk), .rst_n(rst_n), .tach_i(tach_i), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .target_period(target_period)
  );

  localparam int NV = 6;
  localparam int GAP_A [NV] = '{20, 100, 300, 2000, 60, 12};
  localparam int GAP_B [NV] = '{30, 156, 45, 2660, 4, 4};
  localparam int EXPECT[NV] = '{50, 256, 345, 4660, 64, 16};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rise_after(input int n);
    repeat (n - 2) @(negedge clk);
    tach_i = 1'b1;
    repeat (2) @(negedge clk);
    tach_i = 1'b0;
  endtask

  // spacing from the previous capturing edge is a (incl. 10-cycle read phase) then b
  task automatic revolution(input int a, input int b);
    rise_after(a - 10);
    rise_after(b);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; tach_i = 1'b0; addr = '0; rd_en = 1'b0; wr_en = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata", {8'h0, rdata}, 16'h0000);
    check("R1 target_period", target_period, 16'hFFFF);
    rd(8'h1E, d); check("R1 tgt lo", {8'h0, d}, 16'h00FF);
    rd(8'h1F, d); check("R1 tgt hi", {8'h0, d}, 16'h00FF);

    // R2 arming edge alone captures nothing
    tach_i = 1'b1; repeat (2) @(negedge clk); tach_i = 1'b0;
    repeat (2) @(negedge clk);
    rd(8'h08, d); check("R1 R2 meas lo after arm", {8'h0, d}, 16'h0000);
    rd(8'h09, d); check("R1 R2 meas hi after arm", {8'h0, d}, 16'h0000);
    repeat (6) @(negedge clk);

    // R2 vector table
    for (int i = 0; i < NV; i++) begin
      logic [7:0] lo, hi;
      revolution(GAP_A[i], GAP_B[i]);
      rd(8'h08, lo);
      rd(8'h09, hi);
      check("R2 period", {hi, lo}, 16'(EXPECT[i]));
      repeat (6) @(negedge clk);
    end

    // R4 freeze across a newer capture
    revolution(300, 212);                       // 0x0200
    rd(8'h08, d); check("R4 lo", {8'h0, d}, 16'h0000);
    repeat (7) @(negedge clk);
    revolution(400, 368);                       // 0x0300
    rd(8'h09, d); check("R4 frozen hi", {8'h0, d}, 16'h0002);
    rd(8'h09, d); check("R5 live hi after release", {8'h0, d}, 16'h0003);
    rd(8'h08, d); check("R4 lo new", {8'h0, d}, 16'h0000);
    rd(8'h09, d); check("R4 hi matches", {8'h0, d}, 16'h0003);
    repeat (4) @(negedge clk);

    // R5 high read without low read does not freeze
    revolution(200, 216);                       // 0x01A0
    rd(8'h09, d); check("R5 live hi", {8'h0, d}, 16'h0001);
    repeat (7) @(negedge clk);
    revolution(300, 300);                       // 0x0258
    rd(8'h09, d); check("R5 no freeze", {8'h0, d}, 16'h0002);
    rd(8'h08, d); check("R5 lo", {8'h0, d}, 16'h0058);
    rd(8'h09, d); check("R5 hi pair", {8'h0, d}, 16'h0002);
    repeat (5) @(negedge clk);

    // R7 writes to measured bytes ignored
    wr(8'h08, 8'hAA);
    wr(8'h09, 8'hBB);
    rd(8'h08, d); check("R7 lo unchanged", {8'h0, d}, 16'h0058);
    rd(8'h09, d); check("R7 hi unchanged", {8'h0, d}, 16'h0002);

    // R6 target period
    wr(8'h1E, 8'h34);
    wr(8'h1F, 8'h12);
    check("R6 target_period", target_period, 16'h1234);
    rd(8'h1E, d); check("R6 tgt lo", {8'h0, d}, 16'h0034);
    rd(8'h1F, d); check("R6 tgt hi", {8'h0, d}, 16'h0012);

    // R8 undefined addresses, R9 hold
    rd(8'h10, d); check("R8 addr 0x10", {8'h0, d}, 16'h0000);
    rd(8'h1F, d);
    rd(8'h0A, d); check("R8 addr 0x0A", {8'h0, d}, 16'h0000);
    rd(8'h1E, d);
    addr = 8'h10; repeat (3) @(negedge clk);
    check("R9 rdata held", {8'h0, rdata}, 16'h0034);

    // R3 stall saturation
    repeat (70000) @(negedge clk);
    rd(8'h08, d); check("R3 stall lo", {8'h0, d}, 16'h00FF);
    rd(8'h09, d); check("R3 stall hi", {8'h0, d}, 16'h00FF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule